// File: doc/BRIEF.md
# UART Interrupt Identification and FIFO Control

This block sits in the register front end of a 16550-style serial port. It takes the pending conditions of six interrupt sources and turns them into one 4-bit identification code. The code names the most urgent source, or reads 0001 when nothing is pending. An interrupt line follows that code. The transmit-holding-empty source is kept here as a sticky flag. It is set by an event pulse and acknowledged when software reads the identification code while that source is the one reported. The other sources are level inputs that their owners clear.

Writes that land on the same shared address are decoded as FIFO control. The decode stores the FIFO-enable and DMA-mode bits and issues one-clock reset pulses to the receive and transmit FIFO controllers. A reset pulse tells a FIFO controller to treat its FIFO as empty. Any change of the FIFO-enable bit resets both controllers. The FIFOs themselves live outside this block.

Top module: `uart_irq_fifo_ctl`

## Requirements
- R1: After reset the identification code is 0001, irqOut is low, and fifoEn, dmaMode, rxFifoRst and txFifoRst are all low.
- R2: With exactly one source pending, the code is 0110 for line status, 0100 for receive data, 1100 for character timeout, 0010 for transmit holding empty, 0000 for modem status and 0111 for busy detect.
- R3: When several sources are pending, the code is that of the first pending source in this order: line status, receive data, character timeout, transmit holding empty, modem status, busy detect.
- R4: irqOut is high exactly when the identification code differs from 0001.
- R5: On a control write, wrData bit 0 is stored as fifoEn and bit 3 as dmaMode, starting the cycle after the write. Bits above bit 3 have no effect.
- R6: A control write with bit 1 set drives rxFifoRst high, and one with bit 2 set drives txFifoRst high. The pulse comes in the cycle after the write and lasts exactly one clock.
- R7: A control write that changes the stored FIFO-enable value pulses both rxFifoRst and txFifoRst, even when bits 1 and 2 are clear.
- R8: A control write that keeps the FIFO-enable value and has bits 1 and 2 clear produces no reset pulse.
- R9: A pulse on thrEmptySet makes the transmit-holding-empty source pending until regRead is asserted while the code is 0010. A read while another code is reported leaves it pending. A set in the same cycle as an acknowledging read keeps it pending.
- R10: Without a control write, fifoEn and dmaMode keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lsrPend | input | 1 | Receiver line status condition pending |
| rdaPend | input | 1 | Received data available pending |
| ctoPend | input | 1 | Character timeout pending |
| thrEmptySet | input | 1 | Pulse: transmit holding register became empty |
| modemPend | input | 1 | Modem status change pending |
| busyPend | input | 1 | Busy detect pending |
| regRead | input | 1 | Read strobe for the identification code |
| regWrite | input | 1 | Write strobe for the shared address (FIFO control) |
| wrData | input | DATA_W | Write data |
| iidCode | output | 4 | Identification code of the highest-priority pending source |
| irqOut | output | 1 | Interrupt request |
| fifoEn | output | 1 | Stored FIFO-enable bit |
| rxFifoRst | output | 1 | One-clock receive FIFO controller reset |
| txFifoRst | output | 1 | One-clock transmit FIFO controller reset |
| dmaMode | output | 1 | Stored DMA signalling mode |

## Verification
The bench builds the block with its default DATA_W of 8. This leaves four write bits above the decoded field. The bench sets those bits to show that they leave the stored state and the reset pulses unchanged. Because the field positions are the defaults, the bench can drive every combination that matters: enable toggles with and without explicit reset bits, repeated writes of the same enable value, and the acknowledge read racing a new set event.

// File: rtl/uif_pkg.sv
package uif_pkg;
  typedef logic [3:0] iid_t;

  localparam iid_t IID_NONE  = 4'b0001;
  localparam iid_t IID_MODEM = 4'b0000;
  localparam iid_t IID_THRE  = 4'b0010;
  localparam iid_t IID_RDA   = 4'b0100;
  localparam iid_t IID_LSR   = 4'b0110;
  localparam iid_t IID_BUSY  = 4'b0111;
  localparam iid_t IID_CTO   = 4'b1100;

  // strobes from control decode to the datapath
  typedef struct packed {
    logic wr;
    logic fifoEnNew;
    logic rxRst;
    logic txRst;
    logic dmaNew;
    logic thrAck;
  } ctlStb_t;
endpackage

// File: rtl/uif_ctrl.sv
module uif_ctrl
  import uif_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EN_BIT  = 0,
  parameter int RXR_BIT = 1,
  parameter int TXR_BIT = 2,
  parameter int DMA_BIT = 3
) (
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [DATA_W-1:0] wrData,
  input  iid_t              iidCode,
  output ctlStb_t           stb
);
  localparam int FIELD_W = 4;

  // bits above the decoded field carry no meaning
  logic unusedHi;
  assign unusedHi = ^wrData[DATA_W-1:FIELD_W];

  always_comb begin
    stb.wr        = regWrite;
    stb.fifoEnNew = wrData[EN_BIT];
    stb.rxRst     = wrData[RXR_BIT];
    stb.txRst     = wrData[TXR_BIT];
    stb.dmaNew    = wrData[DMA_BIT];
    stb.thrAck    = regRead && (iidCode == IID_THRE);
  end
endmodule

// File: rtl/uif_datapath.sv
module uif_datapath
  import uif_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lsrPend,
  input  logic    rdaPend,
  input  logic    ctoPend,
  input  logic    thrEmptySet,
  input  logic    modemPend,
  input  logic    busyPend,
  input  ctlStb_t stb,
  output iid_t    iidCode,
  output logic    irqOut,
  output logic    fifoEn,
  output logic    rxFifoRst,
  output logic    txFifoRst,
  output logic    dmaMode
);
  logic fifoEnQ, dmaQ, rxRstQ, txRstQ, thrPendQ;
  logic enFlip;

  assign enFlip = stb.fifoEnNew != fifoEnQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifoEnQ  <= 1'b0;
      dmaQ     <= 1'b0;
      rxRstQ   <= 1'b0;
      txRstQ   <= 1'b0;
      thrPendQ <= 1'b0;
    end else begin
      rxRstQ <= stb.wr && (stb.rxRst || enFlip);
      txRstQ <= stb.wr && (stb.txRst || enFlip);
      if (stb.wr) begin
        fifoEnQ <= stb.fifoEnNew;
        dmaQ    <= stb.dmaNew;
      end
      if (thrEmptySet)     thrPendQ <= 1'b1;
      else if (stb.thrAck) thrPendQ <= 1'b0;
    end
  end

  // fixed priority encoder
  always_comb begin
    if (lsrPend)        iidCode = IID_LSR;
    else if (rdaPend)   iidCode = IID_RDA;
    else if (ctoPend)   iidCode = IID_CTO;
    else if (thrPendQ)  iidCode = IID_THRE;
    else if (modemPend) iidCode = IID_MODEM;
    else if (busyPend)  iidCode = IID_BUSY;
    else                iidCode = IID_NONE;
  end

  assign irqOut    = iidCode != IID_NONE;
  assign fifoEn    = fifoEnQ;
  assign dmaMode   = dmaQ;
  assign rxFifoRst = rxRstQ;
  assign txFifoRst = txRstQ;

  // R3
  lsr_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsrPend |-> iidCode == IID_LSR);

  // R6
  rx_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxFifoRst |-> $past(stb.wr));

  // R7
  en_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoEn != $past(fifoEn)) |-> (rxFifoRst && txFifoRst));

  // R9
  thr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.thrAck && !thrEmptySet) |=> !thrPendQ);

  // R10
  dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.wr |=> $stable(dmaMode) && $stable(fifoEn));

  // R4
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lsrPend && !rdaPend && !ctoPend && !thrPendQ && !modemPend && !busyPend)
      |-> (iidCode == IID_NONE && !irqOut));
endmodule

// File: rtl/uart_irq_fifo_ctl.sv
module uart_irq_fifo_ctl
  import uif_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lsrPend,
  input  logic              rdaPend,
  input  logic              ctoPend,
  input  logic              thrEmptySet,
  input  logic              modemPend,
  input  logic              busyPend,
  input  logic              regRead,
  input  logic              regWrite,
  input  logic [DATA_W-1:0] wrData,
  output logic [3:0]        iidCode,
  output logic              irqOut,
  output logic              fifoEn,
  output logic              rxFifoRst,
  output logic              txFifoRst,
  output logic              dmaMode
);
  ctlStb_t stb;
  iid_t    code;

  uif_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .regWrite(regWrite), .regRead(regRead), .wrData(wrData),
    .iidCode(code), .stb(stb)
  );

  uif_datapath dp_i (
    .clk(clk), .rst_n(rst_n),
    .lsrPend(lsrPend), .rdaPend(rdaPend), .ctoPend(ctoPend),
    .thrEmptySet(thrEmptySet), .modemPend(modemPend), .busyPend(busyPend),
    .stb(stb), .iidCode(code), .irqOut(irqOut), .fifoEn(fifoEn),
    .rxFifoRst(rxFifoRst), .txFifoRst(txFifoRst), .dmaMode(dmaMode)
  );

  assign iidCode = code;
endmodule

// File: tb/uart_irq_fifo_ctl_tb_top.sv
module uart_irq_fifo_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lsrPend = 0, rdaPend = 0, ctoPend = 0, thrEmptySet = 0;
  logic modemPend = 0, busyPend = 0, regRead = 0, regWrite = 0;
  logic [7:0] wrData = 8'h00;
  logic [3:0] iidCode;
  logic irqOut, fifoEn, rxFifoRst, txFifoRst, dmaMode;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_fifo_ctl #(.DATA_W(8)) dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic setSrc(input logic [5:0] s);
    {lsrPend, rdaPend, ctoPend, modemPend, busyPend} = {s[5], s[4], s[3], s[1], s[0]};
  endtask

  task automatic fcrWrite(input logic [7:0] d);
    @(negedge clk); regWrite = 1; wrData = d;
    @(negedge clk); regWrite = 0; wrData = 8'h00;
  endtask

  task automatic thrSet();
    @(negedge clk); thrEmptySet = 1;
    @(negedge clk); thrEmptySet = 0;
  endtask

  task automatic iidRead();
    @(negedge clk); regRead = 1;
    @(negedge clk); regRead = 0;
  endtask

  task automatic t_reset();
    chk("R1 code", {4'h0, iidCode}, 8'h01);
    chk("R1 irq", {7'h0, irqOut}, 8'h00);
    chk("R1 outs", {4'h0, fifoEn, dmaMode, rxFifoRst, txFifoRst}, 8'h00);
  endtask

  task automatic t_single();
    setSrc(6'b100000); #1; chk("R2 lsr", {4'h0, iidCode}, 8'h06); chk("R4 irq", {7'h0, irqOut}, 8'h01);
    setSrc(6'b010000); #1; chk("R2 rda", {4'h0, iidCode}, 8'h04);
    setSrc(6'b001000); #1; chk("R2 cto", {4'h0, iidCode}, 8'h0C);
    setSrc(6'b000010); #1; chk("R2 modem", {4'h0, iidCode}, 8'h00);
    chk("R4 irq modem", {7'h0, irqOut}, 8'h01);
    setSrc(6'b000001); #1; chk("R2 busy", {4'h0, iidCode}, 8'h07);
    setSrc(6'b000000); #1; chk("R4 idle", {3'h0, irqOut, iidCode}, 8'h01);
    thrSet(); chk("R2 thre", {4'h0, iidCode}, 8'h02);
    iidRead(); chk("R9 ack", {4'h0, iidCode}, 8'h01);
  endtask

  task automatic t_priority();
    setSrc(6'b111011); #1; chk("R3 all", {4'h0, iidCode}, 8'h06);
    setSrc(6'b011011); #1; chk("R3 rda>cto", {4'h0, iidCode}, 8'h04);
    setSrc(6'b001011); #1; chk("R3 cto>modem", {4'h0, iidCode}, 8'h0C);
    thrSet();
    setSrc(6'b000011); #1; chk("R3 thre>modem", {4'h0, iidCode}, 8'h02);
    iidRead(); chk("R3 modem>busy", {4'h0, iidCode}, 8'h00);
    setSrc(6'b000000); #1;
  endtask

  task automatic t_write();
    fcrWrite(8'h09);
    chk("R5 en/dma", {6'h0, fifoEn, dmaMode}, 8'h03);
    chk("R7 toggle on", {6'h0, rxFifoRst, txFifoRst}, 8'h03);
    @(negedge clk);
    chk("R6 selfclear", {6'h0, rxFifoRst, txFifoRst}, 8'h00);
    chk("R10 hold", {6'h0, fifoEn, dmaMode}, 8'h03);
    fcrWrite(8'hF1);
    chk("R8 no pulse", {6'h0, rxFifoRst, txFifoRst}, 8'h00);
    chk("R5 hi bits", {6'h0, fifoEn, dmaMode}, 8'h02);
    fcrWrite(8'h03);
    chk("R6 rx only", {6'h0, rxFifoRst, txFifoRst}, 8'h02);
    fcrWrite(8'h05);
    chk("R6 tx only", {6'h0, rxFifoRst, txFifoRst}, 8'h01);
    @(negedge clk);
    chk("R6 one clk", {6'h0, rxFifoRst, txFifoRst}, 8'h00);
    fcrWrite(8'h00);
    chk("R7 toggle off", {6'h0, rxFifoRst, txFifoRst}, 8'h03);
    chk("R5 cleared", {6'h0, fifoEn, dmaMode}, 8'h00);
  endtask

  task automatic t_thre();
    thrSet(); lsrPend = 1;
    iidRead(); lsrPend = 0; #1;
    chk("R9 other read", {4'h0, iidCode}, 8'h02);
    @(negedge clk); regRead = 1; thrEmptySet = 1;
    @(negedge clk); regRead = 0; thrEmptySet = 0;
    chk("R9 set wins", {4'h0, iidCode}, 8'h02);
    iidRead(); chk("R9 cleared", {3'h0, irqOut, iidCode}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_priority();
    t_write();
    t_thre();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule